// File: doc/BRIEF.md
# Logical ID to Egress Port Mapper

This block translates an internal 8-bit logical identifier into an 8-bit egress logical port number. It holds a 256-entry table in which each entry carries the port number and an enable flag. The identifier space is divided into four fixed regions of 64 entries, one for each of four upstream modules. A request names a module (0 to 3) and a local identifier (0 to 63) inside that module's region. The table address is formed by concatenating the two fields.

A configuration port writes and reads entries by their full 8-bit address. A lookup port accepts a module number and a local identifier. One cycle later it returns the stored port number, the enable flag and a destination identifier. For an entry whose enable flag is clear, the destination identifier is forced to 0 and a redirect flag is raised, so that traffic for an inactive port is steered to identifier 0. Reads on both ports are registered. When a write and a read hit the same entry in the same cycle, the read sees the contents from before the write.

Top module: `lid_port_mapper`

## Requirements
- R1: After reset every entry holds port 0x00 with the enable flag at 0, and `reg_rd_valid` and `lkp_valid` are low.
- R2: A configuration write stores `reg_wr_data[7:0]` as the port number and `reg_wr_data[8]` as the enable flag at `reg_wr_addr`. A configuration read returns that entry in the same bit layout on `reg_rd_data`, with `reg_rd_valid` high, in the cycle after `reg_rd_en`.
- R3: A lookup with module `m` and local identifier `l` addresses entry `{m[1:0], l[5:0]}`. Module 0 covers 0x00–0x3F, module 1 covers 0x40–0x7F, module 2 covers 0x80–0xBF and module 3 covers 0xC0–0xFF.
- R4: `lkp_valid` is high in exactly the cycle after each cycle with `lkp_req` high, and low otherwise. Back-to-back requests give back-to-back results in request order.
- R5: `lkp_lp` returns bits 7:0 of the addressed entry and `lkp_en` returns bit 8.
- R6: For an enabled entry, `lkp_dest_lid` equals the looked-up address and `lkp_redirect` is 0. For a disabled entry, `lkp_dest_lid` is 0x00 and `lkp_redirect` is 1.
- R7: A lookup issued in the same cycle as a write to the same entry returns the entry's old contents. A lookup one cycle later returns the new contents. A lookup and a configuration read of the same entry in the same cycle return the same contents.
- R8: A configuration read issued in the same cycle as a write to the same address returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr_en | input | 1 | Configuration write strobe |
| reg_wr_addr | input | 8 | Entry address of the write |
| reg_wr_data | input | 9 | Bit 8 is the enable flag, bits 7:0 are the port number |
| reg_rd_en | input | 1 | Configuration read strobe |
| reg_rd_addr | input | 8 | Entry address of the read |
| reg_rd_valid | output | 1 | Read data valid, one cycle after `reg_rd_en` |
| reg_rd_data | output | 9 | Entry contents, in the same layout as `reg_wr_data` |
| lkp_req | input | 1 | Lookup request |
| lkp_module | input | 2 | Upstream module number |
| lkp_local | input | 6 | Local identifier within the module |
| lkp_valid | output | 1 | Lookup result valid |
| lkp_lp | output | 8 | Mapped egress port number |
| lkp_en | output | 1 | Enable flag of the entry |
| lkp_dest_lid | output | 8 | Looked-up address if enabled, otherwise 0x00 |
| lkp_redirect | output | 1 | High when the entry is disabled |

## Verification
Lookups are made with the same local identifier in all four modules, each region holding a different port number and enable setting. This shows whether the module bits really select the region and are not dropped or swapped. The first and last entries (module 0 local 0, module 3 local 63) check the ends of the concatenated address. Same-cycle write-and-lookup and write-and-read patterns separate an old-data read from a write-through read. A stream of back-to-back lookups with alternating enable flags separates correct ordering and latency from off-by-one timing, and it exercises the redirect to identifier 0.

// File: rtl/lid_map_pkg.sv
package lid_map_pkg;
  localparam int LP_W = 8;

  // One table entry; the enable flag sits above the port number.
  typedef struct packed {
    logic            en;
    logic [LP_W-1:0] lp;
  } map_entry_t;

  localparam map_entry_t ENTRY_RST = '{en: 1'b0, lp: '0};
endpackage

// File: rtl/lid_addr_compose.sv
module lid_addr_compose #(
  parameter  int MOD_W   = 2,
  parameter  int LOCAL_W = 6,
  localparam int ADDR_W  = MOD_W + LOCAL_W
) (
  input  logic [MOD_W-1:0]   module_i,
  input  logic [LOCAL_W-1:0] local_i,
  output logic [ADDR_W-1:0]  addr_o
);
  // Module number selects the quadrant, local id indexes inside it.
  assign addr_o = {module_i, local_i};
endmodule

// File: rtl/lid_map_table.sv
module lid_map_table
  import lid_map_pkg::*;
#(
  parameter  int ADDR_W = 8,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  map_entry_t        wr_data,
  input  logic [ADDR_W-1:0] rd_a_addr,
  output map_entry_t        rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_addr,
  output map_entry_t        rd_b_data
);
  map_entry_t mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    map_entry_t ent_d;
    logic       ent_we;

    always_comb begin
      ent_we = wr_en && (wr_addr == ADDR_W'(g));
      ent_d  = ent_we ? wr_data : mem_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= ENTRY_RST;
      end else if (ent_we) begin
        mem_q[g] <= ent_d;
      end
    end
  end

  // Read before write: both ports see the state before this edge.
  assign rd_a_data = mem_q[rd_a_addr];
  assign rd_b_data = mem_q[rd_b_addr];
endmodule

// File: rtl/lid_lookup_stage.sv
module lid_lookup_stage
  import lid_map_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] lid_i,
  input  map_entry_t        entry_i,
  output logic              valid_o,
  output logic [LP_W-1:0]   lp_o,
  output logic              en_o,
  output logic [ADDR_W-1:0] dest_o,
  output logic              redirect_o
);
  logic              valid_q;
  logic [LP_W-1:0]   lp_q,   lp_d;
  logic              en_q,   en_d;
  logic [ADDR_W-1:0] dest_q, dest_d;
  logic              redir_q, redir_d;

  always_comb begin
    lp_d    = entry_i.lp;
    en_d    = entry_i.en;
    // Disabled ports are steered to identifier zero.
    dest_d  = entry_i.en ? lid_i : '0;
    redir_d = ~entry_i.en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= req_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q    <= '0;
      en_q    <= 1'b0;
      dest_q  <= '0;
      redir_q <= 1'b0;
    end else if (req_i) begin
      lp_q    <= lp_d;
      en_q    <= en_d;
      dest_q  <= dest_d;
      redir_q <= redir_d;
    end
  end

  assign valid_o    = valid_q;
  assign lp_o       = lp_q;
  assign en_o       = en_q;
  assign dest_o     = dest_q;
  assign redirect_o = redir_q;
endmodule

// File: rtl/lid_port_mapper.sv
module lid_port_mapper
  import lid_map_pkg::*;
#(
  parameter  int MOD_W   = 2,
  parameter  int LOCAL_W = 6,
  localparam int ADDR_W  = MOD_W + LOCAL_W,
  localparam int ENT_W   = LP_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_wr_addr,
  input  logic [ENT_W-1:0]   reg_wr_data,
  input  logic               reg_rd_en,
  input  logic [ADDR_W-1:0]  reg_rd_addr,
  output logic               reg_rd_valid,
  output logic [ENT_W-1:0]   reg_rd_data,
  input  logic               lkp_req,
  input  logic [MOD_W-1:0]   lkp_module,
  input  logic [LOCAL_W-1:0] lkp_local,
  output logic               lkp_valid,
  output logic [LP_W-1:0]    lkp_lp,
  output logic               lkp_en,
  output logic [ADDR_W-1:0]  lkp_dest_lid,
  output logic               lkp_redirect
);
  logic [ADDR_W-1:0] lkp_addr;
  map_entry_t        wr_entry;
  map_entry_t        cfg_entry;
  map_entry_t        lkp_entry;

  assign wr_entry = map_entry_t'(reg_wr_data);

  lid_addr_compose #(.MOD_W(MOD_W), .LOCAL_W(LOCAL_W)) u_addr (
    .module_i (lkp_module),
    .local_i  (lkp_local),
    .addr_o   (lkp_addr)
  );

  lid_map_table #(.ADDR_W(ADDR_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .wr_addr   (reg_wr_addr),
    .wr_data   (wr_entry),
    .rd_a_addr (reg_rd_addr),
    .rd_a_data (cfg_entry),
    .rd_b_addr (lkp_addr),
    .rd_b_data (lkp_entry)
  );

  lid_lookup_stage #(.ADDR_W(ADDR_W)) u_lookup (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (lkp_req),
    .lid_i      (lkp_addr),
    .entry_i    (lkp_entry),
    .valid_o    (lkp_valid),
    .lp_o       (lkp_lp),
    .en_o       (lkp_en),
    .dest_o     (lkp_dest_lid),
    .redirect_o (lkp_redirect)
  );

  // Configuration read response register.
  logic             rd_valid_q;
  logic [ENT_W-1:0] rd_data_q, rd_data_d;

  always_comb begin
    rd_data_d = ENT_W'(cfg_entry);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= reg_rd_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
    end else if (reg_rd_en) begin
      rd_data_q <= rd_data_d;
    end
  end

  assign reg_rd_valid = rd_valid_q;
  assign reg_rd_data  = rd_data_q;
endmodule

// File: rtl/lid_port_mapper_chk.sv
module lid_port_mapper_chk #(
  parameter  int MOD_W   = 2,
  parameter  int LOCAL_W = 6,
  localparam int ADDR_W  = MOD_W + LOCAL_W,
  localparam int LP_W    = 8,
  localparam int ENT_W   = LP_W + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr_en,
  input logic [ADDR_W-1:0]  reg_wr_addr,
  input logic               reg_rd_en,
  input logic [ADDR_W-1:0]  reg_rd_addr,
  input logic               reg_rd_valid,
  input logic [ENT_W-1:0]   reg_rd_data,
  input logic               lkp_req,
  input logic [MOD_W-1:0]   lkp_module,
  input logic [LOCAL_W-1:0] lkp_local,
  input logic               lkp_valid,
  input logic [LP_W-1:0]    lkp_lp,
  input logic               lkp_en,
  input logic [ADDR_W-1:0]  lkp_dest_lid,
  input logic               lkp_redirect
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_quiet_in_reset_r1: assert (!reg_rd_valid && !lkp_valid);
    end
  end

  p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> reg_rd_valid);

  p_rd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> !reg_rd_valid);

  p_lkp_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_req |=> lkp_valid);

  p_lkp_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_req |=> !lkp_valid);

  p_dest_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_req |=> (!lkp_en || lkp_dest_lid == $past({lkp_module, lkp_local})));

  p_dest_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && !lkp_en) |-> (lkp_dest_lid == '0 && lkp_redirect));

  p_ports_agree_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_req && reg_rd_en && reg_rd_addr == {lkp_module, lkp_local})
    |=> (reg_rd_data == {lkp_en, lkp_lp}));
endmodule

bind lid_port_mapper lid_port_mapper_chk #(.MOD_W(MOD_W), .LOCAL_W(LOCAL_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr_en    (reg_wr_en),
  .reg_wr_addr  (reg_wr_addr),
  .reg_rd_en    (reg_rd_en),
  .reg_rd_addr  (reg_rd_addr),
  .reg_rd_valid (reg_rd_valid),
  .reg_rd_data  (reg_rd_data),
  .lkp_req      (lkp_req),
  .lkp_module   (lkp_module),
  .lkp_local    (lkp_local),
  .lkp_valid    (lkp_valid),
  .lkp_lp       (lkp_lp),
  .lkp_en       (lkp_en),
  .lkp_dest_lid (lkp_dest_lid),
  .lkp_redirect (lkp_redirect)
);

// File: tb/lid_port_mapper_tb_top.sv
`timescale 1ns/1ps
module lid_port_mapper_tb_top;
  logic       clk;
  logic       rst_n;
  logic       reg_wr_en;
  logic [7:0] reg_wr_addr;
  logic [8:0] reg_wr_data;
  logic       reg_rd_en;
  logic [7:0] reg_rd_addr;
  logic       reg_rd_valid;
  logic [8:0] reg_rd_data;
  logic       lkp_req;
  logic [1:0] lkp_module;
  logic [5:0] lkp_local;
  logic       lkp_valid;
  logic [7:0] lkp_lp;
  logic       lkp_en;
  logic [7:0] lkp_dest_lid;
  logic       lkp_redirect;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 1'b0;

  // Bench model of the table: bit 8 enable, bits 7:0 port.
  logic [8:0] model [256];

  // Scoreboard queues: lookup item is {redirect, en, lp, dest}.
  logic [17:0] lkp_exp_q [$];
  string       lkp_tag_q [$];
  logic [8:0]  rd_exp_q  [$];
  string       rd_tag_q  [$];

  lid_port_mapper dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_addr  (reg_wr_addr),
    .reg_wr_data  (reg_wr_data),
    .reg_rd_en    (reg_rd_en),
    .reg_rd_addr  (reg_rd_addr),
    .reg_rd_valid (reg_rd_valid),
    .reg_rd_data  (reg_rd_data),
    .lkp_req      (lkp_req),
    .lkp_module   (lkp_module),
    .lkp_local    (lkp_local),
    .lkp_valid    (lkp_valid),
    .lkp_lp       (lkp_lp),
    .lkp_en       (lkp_en),
    .lkp_dest_lid (lkp_dest_lid),
    .lkp_redirect (lkp_redirect)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One driven cycle: any mix of write, config read and lookup.
  task automatic step(input bit do_wr, input logic [7:0] wa, input logic [8:0] wd,
                      input bit do_rd, input logic [7:0] ra,
                      input bit do_lk, input logic [1:0] md, input logic [5:0] lc,
                      input string tag);
    logic [7:0] la;
    logic [8:0] e;
    la = {md, lc};
    reg_wr_en   = do_wr;  reg_wr_addr = wa;  reg_wr_data = wd;
    reg_rd_en   = do_rd;  reg_rd_addr = ra;
    lkp_req     = do_lk;  lkp_module  = md;  lkp_local   = lc;
    if (do_rd) begin
      rd_exp_q.push_back(model[ra]);
      rd_tag_q.push_back(tag);
    end
    if (do_lk) begin
      e = model[la];
      lkp_exp_q.push_back({~e[8], e[8], e[7:0], (e[8] ? la : 8'h00)});
      lkp_tag_q.push_back(tag);
    end
    if (do_wr) model[wa] = wd;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_rd_en = 1'b0; lkp_req = 1'b0;
  endtask

  // Monitor: compares results against the scoreboard away from the edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (lkp_valid) begin
        if (lkp_exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected lookup valid", 32'(lkp_valid), 32'd0);
        end else begin
          logic [17:0] exp_v;
          logic [17:0] act_v;
          string t;
          exp_v = lkp_exp_q.pop_front();
          t = lkp_tag_q.pop_front();
          act_v = {lkp_redirect, lkp_en, lkp_lp, lkp_dest_lid};
          check(act_v == exp_v, t, 32'(act_v), 32'(exp_v));
        end
      end
      if (reg_rd_valid) begin
        if (rd_exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected read valid", 32'(reg_rd_valid), 32'd0);
        end else begin
          logic [8:0] exp_r;
          string t;
          exp_r = rd_exp_q.pop_front();
          t = rd_tag_q.pop_front();
          check(reg_rd_data == exp_r, t, 32'(reg_rd_data), 32'(exp_r));
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 9'h000;
    rst_n = 1'b0;
    reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0;
    reg_rd_en = 1'b0; reg_rd_addr = '0;
    lkp_req = 1'b0; lkp_module = '0; lkp_local = '0;
    repeat (3) @(negedge clk);
    check(!reg_rd_valid && !lkp_valid, "R1 valids low in reset",
          32'({reg_rd_valid, lkp_valid}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!reg_rd_valid && !lkp_valid, "R1 valids low after reset",
          32'({reg_rd_valid, lkp_valid}), 32'd0);

    // R1: reset contents through both ports, R6 redirect of disabled entries.
    step(0, 0, 0, 1, 8'h00, 1, 2'd0, 6'd0,  "R1 reset entry 0x00");
    step(0, 0, 0, 1, 8'h9A, 1, 2'd2, 6'h1A, "R1 reset entry 0x9A R6");
    step(0, 0, 0, 1, 8'hFF, 1, 2'd3, 6'h3F, "R1 reset entry 0xFF");

    // R2/R3: same local id in all four modules, distinct contents.
    step(1, 8'h05, 9'h111, 0, 0, 0, 0, 0, "R2 write A");
    step(1, 8'h45, 9'h122, 0, 0, 0, 0, 0, "R2 write B");
    step(1, 8'h85, 9'h033, 0, 0, 0, 0, 0, "R2 write C");
    step(1, 8'hC5, 9'h1EE, 0, 0, 0, 0, 0, "R2 write D");
    for (int m = 0; m < 4; m++) begin
      step(0, 0, 0, 1, {m[1:0], 6'd5}, 1, m[1:0], 6'd5, "R3 R5 R6 R2 quadrant lookup");
    end

    // R3 boundaries: first and last entries.
    step(1, 8'h00, 9'h1A5, 0, 0, 0, 0, 0, "R2 write first");
    step(1, 8'hFF, 9'h15A, 0, 0, 0, 0, 0, "R2 write last");
    step(0, 0, 0, 1, 8'h00, 1, 2'd0, 6'd0,  "R3 first entry");
    step(0, 0, 0, 1, 8'hFF, 1, 2'd3, 6'h3F, "R3 last entry");
    step(0, 0, 0, 0, 0,     1, 2'd0, 6'h3F, "R3 module A top unwritten");

    // R7/R8: same-cycle write with lookup and config read to same entry.
    step(1, 8'h47, 9'h1AB, 1, 8'h47, 1, 2'd1, 6'd7, "R7 R8 collision old data");
    step(0, 0, 0, 1, 8'h47, 1, 2'd1, 6'd7, "R7 R8 next cycle new data");
    step(1, 8'h47, 9'h0CD, 0, 0, 1, 2'd1, 6'd7, "R7 collision overwrite old");
    step(0, 0, 0, 0, 0, 1, 2'd1, 6'd7, "R7 disabled after overwrite R6");

    // R4: back-to-back stream with alternating enable flags.
    for (int i = 0; i < 8; i++) begin
      step(1, 8'(8'h20 + i), {i[0], 8'(8'h30 + i)}, 0, 0, 0, 0, 0, "R2 stream fill");
    end
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 0, 0, 0, 1, 2'd0, 6'(6'h20 + i), "R4 R6 back-to-back stream");
    end

    // R6: disable an enabled entry, port number kept.
    step(1, 8'h45, 9'h022, 0, 0, 0, 0, 0, "R2 disable B");
    step(0, 0, 0, 1, 8'h45, 1, 2'd1, 6'd5, "R6 disabled redirect to 0");

    repeat (3) @(negedge clk);
    check(lkp_exp_q.size() == 0 && rd_exp_q.size() == 0, "R4 all results delivered",
          32'(lkp_exp_q.size() + rd_exp_q.size()), 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule